// File: doc/BRIEF.md
# External Data Memory Access Sequencer

This block sits between an 8-bit processor core and an asynchronous external data RAM. The core hands it one request at a time: a 24-bit address, a direction, and for writes a data byte. The sequencer then runs a fixed-shape bus cycle. It drives the address first and waits a setup interval. It then pulses the read or write strobe for a programmable number of clocks. Finally it keeps the address and write data on the pins for a hold interval before it goes idle again.

The strobe width comes from a 3-bit stretch value N, which gives a strobe of N+1 clocks (1 to 8). Slow memories therefore get a longer pulse, and each external move on the core takes longer. For reads, the RAM's data pins are sampled on the last clock of the strobe. The byte is returned together with a one-cycle completion pulse. A ready output tells the core when a new request may be issued.

Top module: `xmem_sequencer`

## Requirements
- R1: After a synchronous reset, `ext_rd`, `ext_wr` and `rsp_done` are low and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the following SETUP_CLKS cycles (default 1), `ext_addr` carries the requested address and both strobes are low.
- R3: The strobe stays high for exactly N+1 consecutive clocks, where N is the stretch value sampled at acceptance. It is never high for more than 2**STR_W clocks.
- R4: `ext_addr` holds the request address throughout the strobe and for HOLD_CLKS cycles (default 1) after the strobe falls.
- R5: On a write, `ext_wdata` holds the request byte throughout the strobe and for HOLD_CLKS cycles after it falls.
- R6: `rsp_done` is high for exactly one cycle: the first cycle after the strobe falls. On a read, `rsp_rdata` then shows the value that was on `ext_rdata` during the last strobe clock. Values present on earlier strobe clocks are not returned.
- R7: `req_ready` is low from acceptance until the sequencer is idle again. Requests, addresses and data presented while it is low have no effect on the running transfer.
- R8: `ext_rd` and `ext_wr` are never high together. A request with `req_write`=1 drives only `ext_wr`, and one with `req_write`=0 drives only `ext_rd`.
- R9: Changing `stretch` after acceptance does not change the width of the running strobe.
- R10: A transfer occupies SETUP_CLKS+N+1+HOLD_CLKS cycles with `req_ready` low. `req_ready` is high again on the cycle after the last hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Request address |
| req_wdata | input | 8 | Write byte |
| stretch | input | 3 | Strobe stretch N (strobe = N+1 clocks) |
| req_ready | output | 1 | Sequencer idle, request may be accepted |
| ext_addr | output | 24 | Address to external RAM |
| ext_rd | output | 1 | Read strobe, active high |
| ext_wr | output | 1 | Write strobe, active high |
| ext_wdata | output | 8 | Write data to external RAM |
| ext_rdata | input | 8 | Read data from external RAM |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read byte |

## Verification
The bench builds the block with its default parameters: a 3-bit stretch, a one-clock setup and a one-clock hold. With these values every strobe width from 1 to 8 clocks can be swept for both directions. At every width the bench predicts the full cycle-by-cycle shape of the transfer from SETUP+N+1+HOLD. On alternate widths it keeps a conflicting request, a different address and an altered stretch on the inputs while the sequencer is busy. It also varies the read bus on each strobe clock, so a capture on any clock other than the last one shows up as a wrong byte.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // Strobe length in clocks for a given stretch code.
  function automatic int unsigned strobe_clocks(input int unsigned stretch_code);
    return stretch_code + 1;
  endfunction

  // Busy length of one transfer in clocks.
  function automatic int unsigned busy_clocks(input int unsigned setup_clks,
                                              input int unsigned stretch_code,
                                              input int unsigned hold_clks);
    return setup_clks + strobe_clocks(stretch_code) + hold_clks;
  endfunction

endpackage

// File: rtl/xmem_req_regs.sv
module xmem_req_regs #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int STR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [STR_W-1:0]  in_stretch,
  output logic              q_write,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata,
  output logic [STR_W-1:0]  q_stretch
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_write   <= 1'b0;
      q_addr    <= '0;
      q_wdata   <= '0;
      q_stretch <= '0;
    end else if (accept) begin
      q_write   <= in_write;
      q_addr    <= in_addr;
      q_wdata   <= in_wdata;
      q_stretch <= in_stretch;
    end
  end

endmodule

// File: rtl/xmem_phase_ctrl.sv
module xmem_phase_ctrl
  import xmem_pkg::*;
#(
  parameter int STR_W      = 3,
  parameter int SETUP_CLKS = 1,
  parameter int HOLD_CLKS  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [STR_W-1:0] stretch_q,
  output phase_e           phase,
  output logic             last_beat
);

  localparam int SPAN  = SETUP_CLKS + HOLD_CLKS + (1 << STR_W) + 1;
  localparam int CNT_W = $clog2(SPAN);

  logic [CNT_W-1:0] cnt;

  assign last_beat = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase <= PH_SETUP;
          cnt   <= CNT_W'(SETUP_CLKS - 1);
        end
        PH_SETUP: if (last_beat) begin
          phase <= PH_STROBE;
          cnt   <= CNT_W'(stretch_q);
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_STROBE: if (last_beat) begin
          phase <= PH_HOLD;
          cnt   <= CNT_W'(HOLD_CLKS - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_HOLD: if (last_beat) begin
          phase <= PH_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xmem_rd_capture.sv
module xmem_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_end,
  input  logic              is_write,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobe_end;
      if (strobe_end && !is_write) rdata <= bus_rdata;
    end
  end

endmodule

// File: rtl/xmem_sequencer.sv
module xmem_sequencer
  import xmem_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int STR_W      = 3,
  parameter int SETUP_CLKS = 1,
  parameter int HOLD_CLKS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [STR_W-1:0]  stretch,
  output logic              req_ready,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);

  phase_e           phase;
  logic             last_beat;
  logic             accept;
  logic             strobe_on;
  logic             strobe_end;
  logic             q_write;
  logic [STR_W-1:0] q_stretch;

  assign req_ready  = (phase == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign strobe_on  = (phase == PH_STROBE);
  assign strobe_end = strobe_on && last_beat;
  assign ext_rd     = strobe_on && !q_write;
  assign ext_wr     = strobe_on && q_write;

  xmem_req_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STR_W(STR_W)) u_regs (
    .clk(clk), .rst(rst), .accept(accept),
    .in_write(req_write), .in_addr(req_addr), .in_wdata(req_wdata),
    .in_stretch(stretch),
    .q_write(q_write), .q_addr(ext_addr), .q_wdata(ext_wdata),
    .q_stretch(q_stretch)
  );

  xmem_phase_ctrl #(.STR_W(STR_W), .SETUP_CLKS(SETUP_CLKS), .HOLD_CLKS(HOLD_CLKS)) u_ctrl (
    .clk(clk), .rst(rst), .accept(accept), .stretch_q(q_stretch),
    .phase(phase), .last_beat(last_beat)
  );

  xmem_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .strobe_end(strobe_end), .is_write(q_write),
    .bus_rdata(ext_rdata), .rdata(rsp_rdata), .done(rsp_done)
  );

endmodule

// File: rtl/xmem_sequencer_chk.sv
module xmem_sequencer_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int STR_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              accept,
  input logic              req_ready,
  input logic              ext_rd,
  input logic              ext_wr,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [DATA_W-1:0] ext_wdata,
  input logic              rsp_done
);

  logic             any_strobe;
  logic [STR_W:0]   run_len;

  assign any_strobe = ext_rd || ext_wr;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (any_strobe) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  a_r8_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
    !(ext_rd && ext_wr));

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  a_r7_strobe_not_ready: assert property (@(posedge clk) disable iff (rst)
    any_strobe |-> !req_ready);

  a_r3_strobe_max: assert property (@(posedge clk) disable iff (rst)
    any_strobe |-> (run_len < (STR_W+1)'(1 << STR_W)));

  a_r2_addr_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(any_strobe) |-> ($stable(ext_addr) && !$past(req_ready)));

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(any_strobe) |-> $stable(ext_addr));

  a_r5_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_wr) |-> $stable(ext_wdata));

  a_r6_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(any_strobe) |-> rsp_done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

endmodule

bind xmem_sequencer xmem_sequencer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STR_W(STR_W)
) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .req_ready(req_ready),
  .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr),
  .ext_wdata(ext_wdata), .rsp_done(rsp_done)
);

// File: tb/tb_xmem_sequencer.sv
`timescale 1ns/1ps
module tb_xmem_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [2:0]  stretch = '0;
  logic        req_ready;
  logic [23:0] ext_addr;
  logic        ext_rd;
  logic        ext_wr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata = '0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xmem_sequencer dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .stretch(stretch),
    .req_ready(req_ready), .ext_addr(ext_addr), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One transfer, checked cycle by cycle (setup 1, strobe n+1, hold 1).
  task automatic xfer(input bit wr, input logic [23:0] a, input logic [7:0] d,
                      input int n, input bit hammer);
    logic [7:0] exp_rd;
    exp_rd = a[7:0] ^ d ^ 8'(n * 37);
    @(negedge clk);
    check(req_ready == 1'b1, "R10 ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    stretch = 3'(n);
    @(negedge clk);
    // setup cycle
    stretch = ~3'(n);                      // R9: changed after acceptance
    if (hammer) begin                      // R7: conflicting request while busy
      req_addr = ~a; req_wdata = ~d; req_write = ~wr;
    end else begin
      req_valid = 1'b0;
    end
    check(!ext_rd && !ext_wr, "R2 strobes low in setup", {30'd0, ext_rd, ext_wr}, 0);
    check(ext_addr == a, "R2 address in setup", 32'(ext_addr), 32'(a));
    check(req_ready == 1'b0, "R7 ready low in setup", 32'(req_ready), 0);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      check(ext_rd == !wr && ext_wr == wr, "R3 R8 strobe level",
            {30'd0, ext_rd, ext_wr}, {30'd0, !wr, wr});
      check(ext_addr == a, "R4 address in strobe", 32'(ext_addr), 32'(a));
      if (wr) check(ext_wdata == d, "R5 wdata in strobe", 32'(ext_wdata), 32'(d));
      check(req_ready == 1'b0, "R7 ready low in strobe", 32'(req_ready), 0);
      ext_rdata = (i == n) ? exp_rd : ~exp_rd;
    end
    @(negedge clk);
    // hold cycle
    check(!ext_rd && !ext_wr, "R3 R9 strobe ends after N+1", {30'd0, ext_rd, ext_wr}, 0);
    check(rsp_done == 1'b1, "R6 done in first hold cycle", 32'(rsp_done), 1);
    check(ext_addr == a, "R4 address hold", 32'(ext_addr), 32'(a));
    if (wr) check(ext_wdata == d, "R5 wdata hold", 32'(ext_wdata), 32'(d));
    else    check(rsp_rdata == exp_rd, "R6 read byte from last strobe clock",
                  32'(rsp_rdata), 32'(exp_rd));
    check(req_ready == 1'b0, "R10 ready low in hold", 32'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b1, "R10 ready after busy span", 32'(req_ready), 1);
    check(rsp_done == 1'b0, "R6 done single cycle", 32'(rsp_done), 0);
    check(ext_addr == a, "R7 busy request ignored", 32'(ext_addr), 32'(a));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!ext_rd && !ext_wr, "R1 strobes low in reset", {30'd0, ext_rd, ext_wr}, 0);
    check(rsp_done == 1'b0, "R1 done low in reset", 32'(rsp_done), 0);
    check(req_ready == 1'b1, "R1 ready high in reset", 32'(req_ready), 1);
    rst = 1'b0;
    for (int n = 0; n < 8; n++) begin
      for (int w = 0; w < 2; w++) begin
        xfer(w[0], 24'hA50000 ^ 24'(n << 16) ^ 24'(w << 9) ^ 24'(n * 3),
             8'(8'h3C + n * 17 + w), n, n[0]);
      end
    end
    xfer(1'b1, 24'hFFFFFF, 8'hFF, 7, 1'b1);
    xfer(1'b0, 24'h000000, 8'h00, 0, 1'b0);
    xfer(1'b0, 24'hFFFFFF, 8'h81, 7, 1'b0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule